// File: doc/BRIEF.md
# IOMMU Translation Lookaside Cache

This block is a fully associative cache of DMA address translations. It sits in front of a page-table walker. Each entry is keyed by the requester's source ID together with the 4 KiB guest frame number of the DMA address. It holds the domain ID, the second-level page-table entry and the read and write permissions for that frame. A lookup that hits returns the cached entry, so the walker is not used. After a walk that missed, the walker writes the result in through the fill port.

Software keeps the cache consistent through three invalidation commands:
- global, which clears everything;
- domain, which clears every entry of one domain;
- page range, which clears the entries of one domain inside a power-of-two-aligned block of frames.

When the cache is full, a fill does not pick a victim. It empties the whole cache and then stores the new entry. All invalidations compare every entry in parallel and finish in one cycle.

Top module: `iotlb_cache`

## Requirements
- R1: The key of an entry is the source ID placed above the 36-bit frame number, which is address bits [47:12]. Address bits [11:0] play no part in matching. A lookup with the same frame number but a different source ID misses.
- R2: A fill whose source ID and frame number equal those of a valid entry overwrites that entry in place and does not create a second copy. Capacity is therefore not consumed.
- R3: A lookup presented in cycle t drives `lk_done_o` high in cycle t+1. On a hit, that cycle also shows `lk_hit_o`=1 with the stored PTE and the stored read and write bits. On a miss, hit, PTE, read and write are all zero.
- R4: When a fill arrives with no matching entry and every slot is valid, all entries are invalidated first. Only the new entry is then valid.
- R5: A domain invalidation clears every valid entry whose 16-bit domain ID equals the supplied one. Other domains are untouched.
- R6: A page-range invalidation with mask value am clears the entries that meet both of these conditions: the domain matches, and the frame number with its low am bits forced to zero equals the supplied frame number with the same bits forced to zero.
- R7: A page-range invalidation with am above 9 is rejected. `pinv_err_o` pulses together with `pinv_done_o`, and no entry changes. With am equal to 9 the command is accepted and `pinv_err_o` stays 0.
- R8: A global invalidation clears every entry, and so does reset.
- R9: When a fill and any invalidation fall in the same cycle, the invalidation is applied first and the fill second. The filled entry survives even if it matches the invalidation. Slots freed by the invalidation are used without a full flush.
- R10: Each of `fill_done_o`, `dinv_done_o`, `pinv_done_o` and `ginv_done_o` is a single-cycle pulse. It comes in the cycle after its command was presented.
- R11: A lookup sees the contents as they were before the fills and invalidations of its own cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lk_valid_i | input | 1 | Lookup request |
| lk_sid_i | input | SID_W | Lookup source ID |
| lk_addr_i | input | ADDR_W | Lookup DMA address |
| lk_done_o | output | 1 | Lookup result valid |
| lk_hit_o | output | 1 | Lookup hit |
| lk_pte_o | output | PTE_W | Cached page-table entry |
| lk_rd_o | output | 1 | Cached read permission |
| lk_wr_o | output | 1 | Cached write permission |
| fill_valid_i | input | 1 | Insert request |
| fill_sid_i | input | SID_W | Insert source ID |
| fill_did_i | input | DID_W | Insert domain ID |
| fill_addr_i | input | ADDR_W | Insert DMA address |
| fill_pte_i | input | PTE_W | Insert page-table entry |
| fill_rd_i | input | 1 | Insert read permission |
| fill_wr_i | input | 1 | Insert write permission |
| fill_done_o | output | 1 | Insert complete |
| dinv_valid_i | input | 1 | Domain invalidation request |
| dinv_did_i | input | DID_W | Domain to clear |
| dinv_done_o | output | 1 | Domain invalidation complete |
| pinv_valid_i | input | 1 | Page-range invalidation request |
| pinv_did_i | input | DID_W | Domain of the range |
| pinv_addr_i | input | ADDR_W | Address inside the range |
| pinv_am_i | input | AM_W | Range mask value |
| pinv_done_o | output | 1 | Page-range invalidation complete |
| pinv_err_o | output | 1 | Page-range request rejected |
| ginv_valid_i | input | 1 | Global invalidation request |
| ginv_done_o | output | 1 | Global invalidation complete |

## Verification
The fill and an invalidation can land in the same cycle. This collision is the main concurrency case. The bench provokes it in two ways, each time by raising the fill request and a domain invalidation on the same clock edge. In the first, the cache is full, the invalidation frees two slots, and a new frame is filled. The survivors and the new frame must all hit, and the invalidated frames must miss, which shows that no flush took place. In the second, the fill rewrites an entry of the domain that is being cleared. That entry must hit with its new PTE, while its domain sibling misses. A lookup issued in the same cycle as a fill is also checked to miss, then to hit once the fill has landed.

// File: rtl/iotlb_pkg.sv
package iotlb_pkg;
  localparam int unsigned PAGE_SHIFT = 12;

  typedef enum logic [1:0] {
    ALLOC_NONE,
    ALLOC_REPLACE,
    ALLOC_FREE,
    ALLOC_FLUSH
  } alloc_kind_e;
endpackage

// File: rtl/iotlb_slot.sv
module iotlb_slot #(
  parameter int unsigned SID_W = 16,
  parameter int unsigned GFN_W = 36,
  parameter int unsigned DID_W = 16,
  parameter int unsigned PTE_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic             kill_i,
  input  logic [SID_W-1:0] wr_sid_i,
  input  logic [GFN_W-1:0] wr_gfn_i,
  input  logic [DID_W-1:0] wr_did_i,
  input  logic [PTE_W-1:0] wr_pte_i,
  input  logic             wr_rd_i,
  input  logic             wr_wr_i,
  input  logic [SID_W-1:0] lk_sid_i,
  input  logic [GFN_W-1:0] lk_gfn_i,
  input  logic             dinv_en_i,
  input  logic [DID_W-1:0] dinv_did_i,
  input  logic             pinv_en_i,
  input  logic [DID_W-1:0] pinv_did_i,
  input  logic [GFN_W-1:0] pinv_gfn_i,
  input  logic [GFN_W-1:0] pinv_mask_i,
  output logic             valid_o,
  output logic             lk_hit_o,
  output logic             fill_match_o,
  output logic             inv_hit_o,
  output logic [PTE_W-1:0] pte_o,
  output logic             rd_o,
  output logic             wr_o
);
  logic             valid_q;
  logic [SID_W-1:0] sid_q;
  logic [GFN_W-1:0] gfn_q;
  logic [DID_W-1:0] did_q;
  logic [PTE_W-1:0] pte_q;
  logic             rd_q, wr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      sid_q   <= '0;
      gfn_q   <= '0;
      did_q   <= '0;
      pte_q   <= '0;
      rd_q    <= 1'b0;
      wr_q    <= 1'b0;
    end else if (wr_i) begin
      // write wins: invalidation is ordered before the fill
      valid_q <= 1'b1;
      sid_q   <= wr_sid_i;
      gfn_q   <= wr_gfn_i;
      did_q   <= wr_did_i;
      pte_q   <= wr_pte_i;
      rd_q    <= wr_rd_i;
      wr_q    <= wr_wr_i;
    end else if (kill_i) begin
      valid_q <= 1'b0;
    end
  end

  logic dom_hit, page_hit;
  assign dom_hit  = dinv_en_i && (did_q == dinv_did_i);
  assign page_hit = pinv_en_i && (did_q == pinv_did_i) &&
                    ((gfn_q & pinv_mask_i) == (pinv_gfn_i & pinv_mask_i));

  assign valid_o      = valid_q;
  assign lk_hit_o     = valid_q && (sid_q == lk_sid_i) && (gfn_q == lk_gfn_i);
  assign fill_match_o = valid_q && (sid_q == wr_sid_i) && (gfn_q == wr_gfn_i);
  assign inv_hit_o    = valid_q && (dom_hit || page_hit);
  assign pte_o        = pte_q;
  assign rd_o         = rd_q;
  assign wr_o         = wr_q;

  p_wr_sets_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> valid_q);
  p_kill_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (kill_i && !wr_i) |=> !valid_q);
endmodule

// File: rtl/iotlb_alloc.sv
module iotlb_alloc #(
  parameter int unsigned N     = 1024,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     free_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  // lowest free slot
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (free_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end
endmodule

// File: rtl/iotlb_pinv_dec.sv
module iotlb_pinv_dec #(
  parameter int unsigned GFN_W  = 36,
  parameter int unsigned AM_W   = 6,
  parameter int unsigned MAX_AM = 9
) (
  input  logic             valid_i,
  input  logic [AM_W-1:0]  am_i,
  output logic             en_o,
  output logic             reject_o,
  output logic [GFN_W-1:0] mask_o
);
  logic am_ok;
  assign am_ok    = (int'(am_i) <= int'(MAX_AM));
  assign en_o     = valid_i && am_ok;
  assign reject_o = valid_i && !am_ok;

  always_comb begin
    for (int j = 0; j < int'(GFN_W); j++) begin
      mask_o[j] = (int'(am_i) <= j);
    end
  end
endmodule

// File: rtl/iotlb_cache.sv
module iotlb_cache
  import iotlb_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 1024,
  parameter int unsigned ADDR_W      = 48,
  parameter int unsigned SID_W       = 16,
  parameter int unsigned DID_W       = 16,
  parameter int unsigned PTE_W       = 64,
  parameter int unsigned AM_W        = 6,
  parameter int unsigned MAX_AM      = 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lk_valid_i,
  input  logic [SID_W-1:0]  lk_sid_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  output logic              lk_done_o,
  output logic              lk_hit_o,
  output logic [PTE_W-1:0]  lk_pte_o,
  output logic              lk_rd_o,
  output logic              lk_wr_o,
  input  logic              fill_valid_i,
  input  logic [SID_W-1:0]  fill_sid_i,
  input  logic [DID_W-1:0]  fill_did_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [PTE_W-1:0]  fill_pte_i,
  input  logic              fill_rd_i,
  input  logic              fill_wr_i,
  output logic              fill_done_o,
  input  logic              dinv_valid_i,
  input  logic [DID_W-1:0]  dinv_did_i,
  output logic              dinv_done_o,
  input  logic              pinv_valid_i,
  input  logic [DID_W-1:0]  pinv_did_i,
  input  logic [ADDR_W-1:0] pinv_addr_i,
  input  logic [AM_W-1:0]   pinv_am_i,
  output logic              pinv_done_o,
  output logic              pinv_err_o,
  input  logic              ginv_valid_i,
  output logic              ginv_done_o
);
  localparam int unsigned N     = NUM_ENTRIES;
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;
  localparam int unsigned GFN_W = ADDR_W - PAGE_SHIFT;

  logic [GFN_W-1:0] lk_gfn, fill_gfn, pinv_gfn;
  assign lk_gfn   = lk_addr_i[ADDR_W-1:PAGE_SHIFT];
  assign fill_gfn = fill_addr_i[ADDR_W-1:PAGE_SHIFT];
  assign pinv_gfn = pinv_addr_i[ADDR_W-1:PAGE_SHIFT];

  logic unused_offset_bits;
  assign unused_offset_bits = ^{lk_addr_i[PAGE_SHIFT-1:0], fill_addr_i[PAGE_SHIFT-1:0],
                                pinv_addr_i[PAGE_SHIFT-1:0]};

  // page-range command decode
  logic             pinv_en, pinv_reject;
  logic [GFN_W-1:0] pinv_mask;

  iotlb_pinv_dec #(
    .GFN_W (GFN_W),
    .AM_W  (AM_W),
    .MAX_AM(MAX_AM)
  ) u_pinv_dec (
    .valid_i (pinv_valid_i),
    .am_i    (pinv_am_i),
    .en_o    (pinv_en),
    .reject_o(pinv_reject),
    .mask_o  (pinv_mask)
  );

  // entry array
  logic [N-1:0]     valid_vec, lk_hit_vec, fill_match_vec, inv_hit_vec;
  logic [N-1:0]     wr_vec, kill_vec;
  logic [PTE_W-1:0] slot_pte [N];
  logic [N-1:0]     slot_rd, slot_wr;

  for (genvar g = 0; g < N; g++) begin : g_slot
    iotlb_slot #(
      .SID_W(SID_W),
      .GFN_W(GFN_W),
      .DID_W(DID_W),
      .PTE_W(PTE_W)
    ) u_slot (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_i        (wr_vec[g]),
      .kill_i      (kill_vec[g]),
      .wr_sid_i    (fill_sid_i),
      .wr_gfn_i    (fill_gfn),
      .wr_did_i    (fill_did_i),
      .wr_pte_i    (fill_pte_i),
      .wr_rd_i     (fill_rd_i),
      .wr_wr_i     (fill_wr_i),
      .lk_sid_i    (lk_sid_i),
      .lk_gfn_i    (lk_gfn),
      .dinv_en_i   (dinv_valid_i),
      .dinv_did_i  (dinv_did_i),
      .pinv_en_i   (pinv_en),
      .pinv_did_i  (pinv_did_i),
      .pinv_gfn_i  (pinv_gfn),
      .pinv_mask_i (pinv_mask),
      .valid_o     (valid_vec[g]),
      .lk_hit_o    (lk_hit_vec[g]),
      .fill_match_o(fill_match_vec[g]),
      .inv_hit_o   (inv_hit_vec[g]),
      .pte_o       (slot_pte[g]),
      .rd_o        (slot_rd[g]),
      .wr_o        (slot_wr[g])
    );
  end

  // invalidation first, then fill against the surviving set
  logic [N-1:0] pre_kill, valid_after, repl_vec;
  logic         repl_any;
  assign pre_kill    = inv_hit_vec | {N{ginv_valid_i}};
  assign valid_after = valid_vec & ~pre_kill;
  assign repl_vec    = fill_match_vec & valid_after;
  assign repl_any    = |repl_vec;

  logic [IDX_W-1:0] free_idx;
  logic             free_any;

  iotlb_alloc #(
    .N    (N),
    .IDX_W(IDX_W)
  ) u_alloc (
    .free_i(~valid_after),
    .idx_o (free_idx),
    .any_o (free_any)
  );

  alloc_kind_e alloc_kind;

  always_comb begin
    alloc_kind = ALLOC_NONE;
    wr_vec     = '0;
    if (fill_valid_i) begin
      if (repl_any) begin
        alloc_kind = ALLOC_REPLACE;
        wr_vec     = repl_vec;
      end else if (free_any) begin
        alloc_kind       = ALLOC_FREE;
        wr_vec[free_idx] = 1'b1;
      end else begin
        alloc_kind = ALLOC_FLUSH;
        wr_vec[0]  = 1'b1;
      end
    end
  end

  assign kill_vec = pre_kill | {N{alloc_kind == ALLOC_FLUSH}};

  // lookup read-out, one-hot select
  logic [PTE_W-1:0] sel_pte;
  logic             sel_rd, sel_wr, sel_hit;

  always_comb begin
    sel_pte = '0;
    sel_rd  = 1'b0;
    sel_wr  = 1'b0;
    for (int i = 0; i < int'(N); i++) begin
      if (lk_hit_vec[i]) begin
        sel_pte = sel_pte | slot_pte[i];
        sel_rd  = sel_rd | slot_rd[i];
        sel_wr  = sel_wr | slot_wr[i];
      end
    end
  end
  assign sel_hit = lk_valid_i && (|lk_hit_vec);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lk_done_o   <= 1'b0;
      lk_hit_o    <= 1'b0;
      lk_pte_o    <= '0;
      lk_rd_o     <= 1'b0;
      lk_wr_o     <= 1'b0;
      fill_done_o <= 1'b0;
      dinv_done_o <= 1'b0;
      pinv_done_o <= 1'b0;
      pinv_err_o  <= 1'b0;
      ginv_done_o <= 1'b0;
    end else begin
      lk_done_o   <= lk_valid_i;
      lk_hit_o    <= sel_hit;
      lk_pte_o    <= sel_hit ? sel_pte : '0;
      lk_rd_o     <= sel_hit && sel_rd;
      lk_wr_o     <= sel_hit && sel_wr;
      fill_done_o <= fill_valid_i;
      dinv_done_o <= dinv_valid_i;
      pinv_done_o <= pinv_valid_i;
      pinv_err_o  <= pinv_reject;
      ginv_done_o <= ginv_valid_i;
    end
  end

  p_hit_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_hit_vec));
  p_wr_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(wr_vec));
  p_flush_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_kind == ALLOC_FLUSH) |=> ($countones(valid_vec) == 1));
  p_reject_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pinv_reject && !fill_valid_i && !dinv_valid_i && !ginv_valid_i)
      |=> (valid_vec == $past(valid_vec)));
  p_miss_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lk_done_o && !lk_hit_o) |-> (lk_pte_o == '0 && !lk_rd_o && !lk_wr_o));
endmodule

// File: tb/iotlb_cache_tb_top.sv
module iotlb_cache_tb_top;
  localparam int unsigned N      = 4;
  localparam int unsigned ADDR_W = 48;
  localparam int unsigned SID_W  = 16;
  localparam int unsigned DID_W  = 16;
  localparam int unsigned PTE_W  = 64;
  localparam int unsigned AM_W   = 6;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              lk_valid_i = 1'b0;
  logic [SID_W-1:0]  lk_sid_i = '0;
  logic [ADDR_W-1:0] lk_addr_i = '0;
  logic              lk_done_o, lk_hit_o, lk_rd_o, lk_wr_o;
  logic [PTE_W-1:0]  lk_pte_o;
  logic              fill_valid_i = 1'b0;
  logic [SID_W-1:0]  fill_sid_i = '0;
  logic [DID_W-1:0]  fill_did_i = '0;
  logic [ADDR_W-1:0] fill_addr_i = '0;
  logic [PTE_W-1:0]  fill_pte_i = '0;
  logic              fill_rd_i = 1'b0, fill_wr_i = 1'b0;
  logic              fill_done_o;
  logic              dinv_valid_i = 1'b0;
  logic [DID_W-1:0]  dinv_did_i = '0;
  logic              dinv_done_o;
  logic              pinv_valid_i = 1'b0;
  logic [DID_W-1:0]  pinv_did_i = '0;
  logic [ADDR_W-1:0] pinv_addr_i = '0;
  logic [AM_W-1:0]   pinv_am_i = '0;
  logic              pinv_done_o, pinv_err_o;
  logic              ginv_valid_i = 1'b0;
  logic              ginv_done_o;

  int total = 0;
  int bad   = 0;

  always #2 clk = ~clk;

  iotlb_cache #(
    .NUM_ENTRIES(N), .ADDR_W(ADDR_W), .SID_W(SID_W), .DID_W(DID_W),
    .PTE_W(PTE_W), .AM_W(AM_W), .MAX_AM(9)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_ni),
    .lk_valid_i(lk_valid_i), .lk_sid_i(lk_sid_i), .lk_addr_i(lk_addr_i),
    .lk_done_o(lk_done_o), .lk_hit_o(lk_hit_o), .lk_pte_o(lk_pte_o),
    .lk_rd_o(lk_rd_o), .lk_wr_o(lk_wr_o),
    .fill_valid_i(fill_valid_i), .fill_sid_i(fill_sid_i), .fill_did_i(fill_did_i),
    .fill_addr_i(fill_addr_i), .fill_pte_i(fill_pte_i), .fill_rd_i(fill_rd_i),
    .fill_wr_i(fill_wr_i), .fill_done_o(fill_done_o),
    .dinv_valid_i(dinv_valid_i), .dinv_did_i(dinv_did_i), .dinv_done_o(dinv_done_o),
    .pinv_valid_i(pinv_valid_i), .pinv_did_i(pinv_did_i), .pinv_addr_i(pinv_addr_i),
    .pinv_am_i(pinv_am_i), .pinv_done_o(pinv_done_o), .pinv_err_o(pinv_err_o),
    .ginv_valid_i(ginv_valid_i), .ginv_done_o(ginv_done_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] pa(input logic [35:0] gfn, input logic [11:0] off);
    return {gfn, off};
  endfunction

  task automatic set_fill(input logic [15:0] sid, input logic [15:0] did,
                          input logic [35:0] gfn, input logic [63:0] pte,
                          input logic rd, input logic wr);
    fill_valid_i = 1'b1;
    fill_sid_i   = sid;
    fill_did_i   = did;
    fill_addr_i  = pa(gfn, 12'h0);
    fill_pte_i   = pte;
    fill_rd_i    = rd;
    fill_wr_i    = wr;
  endtask

  task automatic do_fill(input logic [15:0] sid, input logic [15:0] did,
                         input logic [35:0] gfn, input logic [63:0] pte);
    @(negedge clk);
    set_fill(sid, did, gfn, pte, 1'b1, 1'b1);
    @(negedge clk);
    fill_valid_i = 1'b0;
    chk("R10 fill_done", 64'(fill_done_o), 64'd1);
  endtask

  task automatic expect_lk(input string req, input logic [15:0] sid,
                           input logic [35:0] gfn, input logic [11:0] off,
                           input logic hit, input logic [63:0] pte,
                           input logic rd, input logic wr);
    @(negedge clk);
    lk_valid_i = 1'b1;
    lk_sid_i   = sid;
    lk_addr_i  = pa(gfn, off);
    @(negedge clk);
    lk_valid_i = 1'b0;
    chk({req, " done"}, 64'(lk_done_o), 64'd1);
    chk({req, " hit"}, 64'(lk_hit_o), 64'(hit));
    chk({req, " pte"}, lk_pte_o, pte);
    chk({req, " perm"}, {62'd0, lk_rd_o, lk_wr_o}, {62'd0, rd, wr});
  endtask

  task automatic do_ginv();
    @(negedge clk);
    ginv_valid_i = 1'b1;
    @(negedge clk);
    ginv_valid_i = 1'b0;
    chk("R10 ginv_done", 64'(ginv_done_o), 64'd1);
  endtask

  task automatic do_dinv(input logic [15:0] did);
    @(negedge clk);
    dinv_valid_i = 1'b1;
    dinv_did_i   = did;
    @(negedge clk);
    dinv_valid_i = 1'b0;
    chk("R10 dinv_done", 64'(dinv_done_o), 64'd1);
    @(negedge clk);
    chk("R10 dinv_done single pulse", 64'(dinv_done_o), 64'd0);
  endtask

  task automatic do_pinv(input logic [15:0] did, input logic [35:0] gfn,
                         input logic [5:0] am, input logic exp_err);
    @(negedge clk);
    pinv_valid_i = 1'b1;
    pinv_did_i   = did;
    pinv_addr_i  = pa(gfn, 12'h7ff);
    pinv_am_i    = am;
    @(negedge clk);
    pinv_valid_i = 1'b0;
    chk("R10 pinv_done", 64'(pinv_done_o), 64'd1);
    chk("R7 pinv_err", 64'(pinv_err_o), 64'(exp_err));
  endtask

  task automatic t_reset();
    chk("R8 reset lk_done", 64'(lk_done_o), 64'd0);
    chk("R10 reset fill_done", 64'(fill_done_o), 64'd0);
    expect_lk("R8 reset empty", 16'h1, 36'h10, 12'h0, 1'b0, 64'd0, 1'b0, 1'b0);
  endtask

  task automatic t_tag_and_hit();
    do_ginv();
    @(negedge clk);
    set_fill(16'h1, 16'h1, 36'h10, 64'hAAAA_0000_1234_5000, 1'b1, 1'b0);
    @(negedge clk);
    fill_valid_i = 1'b0;
    expect_lk("R3 hit", 16'h1, 36'h10, 12'h0, 1'b1, 64'hAAAA_0000_1234_5000, 1'b1, 1'b0);
    expect_lk("R1 offset ignored", 16'h1, 36'h10, 12'hfff, 1'b1, 64'hAAAA_0000_1234_5000, 1'b1, 1'b0);
    expect_lk("R1 other sid misses", 16'h2, 36'h10, 12'h0, 1'b0, 64'd0, 1'b0, 1'b0);
    expect_lk("R3 other gfn misses", 16'h1, 36'h11, 12'h0, 1'b0, 64'd0, 1'b0, 1'b0);
  endtask

  task automatic t_replace();
    do_ginv();
    do_fill(16'h1, 16'h1, 36'h20, 64'd1);
    @(negedge clk);
    set_fill(16'h1, 16'h1, 36'h20, 64'd2, 1'b0, 1'b1);
    @(negedge clk);
    fill_valid_i = 1'b0;
    do_fill(16'h1, 16'h1, 36'h21, 64'd3);
    do_fill(16'h1, 16'h1, 36'h22, 64'd4);
    do_fill(16'h1, 16'h1, 36'h23, 64'd5);
    expect_lk("R2 replaced in place", 16'h1, 36'h20, 12'h0, 1'b1, 64'd2, 1'b0, 1'b1);
    expect_lk("R2 no flush", 16'h1, 36'h23, 12'h0, 1'b1, 64'd5, 1'b1, 1'b1);
  endtask

  task automatic t_full_flush();
    do_fill(16'h1, 16'h1, 36'h24, 64'd6);
    expect_lk("R4 old entry gone", 16'h1, 36'h20, 12'h0, 1'b0, 64'd0, 1'b0, 1'b0);
    expect_lk("R4 old entry gone", 16'h1, 36'h23, 12'h0, 1'b0, 64'd0, 1'b0, 1'b0);
    expect_lk("R4 new entry kept", 16'h1, 36'h24, 12'h0, 1'b1, 64'd6, 1'b1, 1'b1);
  endtask

  task automatic t_domain_inv();
    do_ginv();
    do_fill(16'h1, 16'h1, 36'h30, 64'h30);
    do_fill(16'h2, 16'h2, 36'h31, 64'h31);
    do_fill(16'h3, 16'h1, 36'h32, 64'h32);
    do_dinv(16'h1);
    expect_lk("R5 dom1 cleared", 16'h1, 36'h30, 12'h0, 1'b0, 64'd0, 1'b0, 1'b0);
    expect_lk("R5 dom1 cleared", 16'h3, 36'h32, 12'h0, 1'b0, 64'd0, 1'b0, 1'b0);
    expect_lk("R5 dom2 kept", 16'h2, 36'h31, 12'h0, 1'b1, 64'h31, 1'b1, 1'b1);
  endtask

  task automatic t_page_inv();
    do_ginv();
    do_fill(16'h1, 16'h3, 36'h100, 64'h100);
    do_fill(16'h1, 16'h3, 36'h103, 64'h103);
    do_fill(16'h1, 16'h3, 36'h104, 64'h104);
    do_fill(16'h1, 16'h4, 36'h101, 64'h101);
    do_pinv(16'h3, 36'h102, 6'd2, 1'b0);
    expect_lk("R6 range low cleared", 16'h1, 36'h100, 12'h0, 1'b0, 64'd0, 1'b0, 1'b0);
    expect_lk("R6 range high cleared", 16'h1, 36'h103, 12'h0, 1'b0, 64'd0, 1'b0, 1'b0);
    expect_lk("R6 outside range kept", 16'h1, 36'h104, 12'h0, 1'b1, 64'h104, 1'b1, 1'b1);
    expect_lk("R6 other domain kept", 16'h1, 36'h101, 12'h0, 1'b1, 64'h101, 1'b1, 1'b1);
  endtask

  task automatic t_am_limit();
    do_ginv();
    do_fill(16'h2, 16'h6, 36'h3ff, 64'h3ff);
    do_fill(16'h2, 16'h6, 36'h400, 64'h400);
    do_pinv(16'h6, 36'h200, 6'd10, 1'b1);
    expect_lk("R7 rejected no change", 16'h2, 36'h3ff, 12'h0, 1'b1, 64'h3ff, 1'b1, 1'b1);
    do_pinv(16'h6, 36'h200, 6'd9, 1'b0);
    expect_lk("R7 am9 accepted", 16'h2, 36'h3ff, 12'h0, 1'b0, 64'd0, 1'b0, 1'b0);
    expect_lk("R7 am9 outside kept", 16'h2, 36'h400, 12'h0, 1'b1, 64'h400, 1'b1, 1'b1);
  endtask

  task automatic t_global();
    do_ginv();
    expect_lk("R8 global cleared", 16'h2, 36'h400, 12'h0, 1'b0, 64'd0, 1'b0, 1'b0);
  endtask

  task automatic t_same_cycle();
    do_ginv();
    do_fill(16'h3, 16'h5, 36'h1, 64'h1);
    do_fill(16'h3, 16'h5, 36'h2, 64'h2);
    do_fill(16'h3, 16'h7, 36'h3, 64'h3);
    do_fill(16'h3, 16'h7, 36'h4, 64'h4);
    // cache full: invalidation frees two slots in the same cycle as the fill
    @(negedge clk);
    dinv_valid_i = 1'b1;
    dinv_did_i   = 16'h5;
    set_fill(16'h3, 16'h5, 36'h9, 64'h9, 1'b1, 1'b1);
    @(negedge clk);
    dinv_valid_i = 1'b0;
    fill_valid_i = 1'b0;
    chk("R10 both done", {62'd0, dinv_done_o, fill_done_o}, 64'd3);
    expect_lk("R9 inv then fill", 16'h3, 36'h9, 12'h0, 1'b1, 64'h9, 1'b1, 1'b1);
    expect_lk("R9 cleared", 16'h3, 36'h1, 12'h0, 1'b0, 64'd0, 1'b0, 1'b0);
    expect_lk("R9 no flush", 16'h3, 36'h3, 12'h0, 1'b1, 64'h3, 1'b1, 1'b1);
    // fill rewrites an entry of the domain being cleared
    @(negedge clk);
    dinv_valid_i = 1'b1;
    dinv_did_i   = 16'h7;
    set_fill(16'h3, 16'h7, 36'h3, 64'h33, 1'b0, 1'b0);
    @(negedge clk);
    dinv_valid_i = 1'b0;
    fill_valid_i = 1'b0;
    expect_lk("R9 refilled survives", 16'h3, 36'h3, 12'h0, 1'b1, 64'h33, 1'b0, 1'b0);
    expect_lk("R9 sibling cleared", 16'h3, 36'h4, 12'h0, 1'b0, 64'd0, 1'b0, 1'b0);
  endtask

  task automatic t_lookup_order();
    do_ginv();
    @(negedge clk);
    set_fill(16'h5, 16'h1, 36'h77, 64'h77, 1'b1, 1'b1);
    lk_valid_i = 1'b1;
    lk_sid_i   = 16'h5;
    lk_addr_i  = pa(36'h77, 12'h0);
    @(negedge clk);
    fill_valid_i = 1'b0;
    lk_valid_i   = 1'b0;
    chk("R11 same-cycle lookup misses", 64'(lk_hit_o), 64'd0);
    expect_lk("R11 later lookup hits", 16'h5, 36'h77, 12'h0, 1'b1, 64'h77, 1'b1, 1'b1);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(4 * 200000);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_tag_and_hit();
    t_replace();
    t_full_flush();
    t_domain_inv();
    t_page_inv();
    t_am_limit();
    t_global();
    t_same_cycle();
    t_lookup_order();
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule